// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block places one test cell in the path of every input pin and every output pin of a small design and links all of the cells into one serial chain. A test controller outside the block drives plain capture, shift and update strobes together with a test-mode select. In normal mode every cell is transparent. Each input pin drives its core signal directly, and each core output drives its pin directly, as if no test logic were present.

In test mode the core sees the values held in the input cells' update latches, and the pins see the values held in the output cells' update latches. A tester first shifts a full pattern in through the serial input. One update strobe then applies the whole pattern in parallel. A capture strobe samples the pins and the core outputs into the cells in parallel. The captured response is then shifted out on the serial output.

Each cell has a shift flip-flop and a separate update latch, so the parallel outputs hold steady while a pattern is moving through the chain. The serial output is retimed onto the falling edge of the test clock.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds N_IN + N_OUT stages. Stage 0 takes the serial input, and stages N_IN-1 down to 0 are the input-pin cells in ascending pin order. Stages N_IN to N_IN+N_OUT-1 are the output-pin cells in ascending pin order. The last stage feeds the serial output, so the bit shifted in first leaves the serial output first, N_IN + N_OUT shifts later.
- R2: When `mode` is 0, `core_in` equals `pin_in` and `pin_out` equals `core_out` in the same cycle, whatever the chain and its strobes are doing.
- R3: At a rising `tck` edge with `shift`=1 and `capture`=0, every stage takes the value of the stage before it, and stage 0 takes `tdi`.
- R4: At a rising `tck` edge with `capture`=1, input cell i loads `pin_in[i]` and output cell j loads `core_out[j]`, all at once. Capture takes priority over a shift requested at the same edge.
- R5: At a rising `tck` edge with `update`=1, every update latch loads the value its shift stage held before that edge. With `update`=0 the update latches keep their values, including while shifting.
- R6: When `mode` is 1, `core_in[i]` shows input cell i's update latch and `pin_out[j]` shows output cell j's update latch.
- R7: `tdo` changes only at a falling `tck` edge, where it takes the value of the last chain stage.
- R8: A rising `tck` edge with `rst_n`=0 clears all shift stages and update latches. A falling edge with `rst_n`=0 clears `tdo`.
- R9: At a rising edge with `capture`, `shift` and `update` all 0, the chain contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture | input | 1 | Parallel-load strobe into the shift stages |
| shift | input | 1 | Move chain one stage toward the serial output |
| update | input | 1 | Copy shift stages into the update latches |
| mode | input | 1 | 0 selects the functional path, 1 the update latches |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| pin_in | input | N_IN | Values seen at the input pins |
| core_in | output | N_IN | Inputs delivered to the core |
| core_out | input | N_OUT | Outputs produced by the core |
| pin_out | output | N_OUT | Values driven to the output pins |

## Verification
The bench builds the chain with five input cells and three output cells. Because the two counts differ, a swap of the two cell groups, a misplaced boundary between them, or a reversed order inside a group changes the bit order seen at the serial output. An eight-stage chain is short enough for a full flush and a complete pattern load within a few cycles, so the tests also cover shift during test mode, capture and shift requested together, and a reset in the middle of a run.

// File: rtl/bscan_pkg.sv
// Package: shared types for the boundary scan chain.
// Assumes: one operation on the shift stage per clock edge.
package bscan_pkg;

    // Operation applied to every shift stage at a rising edge
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } cell_op_e;

endpackage

// File: rtl/bscan_op_decode.sv
// Module: turns the raw capture/shift strobes into one cell operation.
// Assumes: capture outranks shift when both are raised together.
module bscan_op_decode
    import bscan_pkg::*;
(
    input  logic     tck,
    input  logic     rst_n,
    input  logic     capture,
    input  logic     shift,
    output cell_op_e op
);

    // Priority decode of the strobes
    always_comb begin
        if (capture)
            op = OP_CAPTURE;
        else if (shift)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
    end

    // R4: a capture request is never reported as a shift
    p_capture_wins_r4: assert property (@(posedge tck) disable iff (!rst_n)
        capture |-> op == OP_CAPTURE);

    // R9: with neither strobe raised the stages are told to hold
    p_idle_holds_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (!capture && !shift) |-> op == OP_HOLD);

endmodule

// File: rtl/bscan_cell.sv
// Module: one boundary cell, with a shift flip-flop, an update latch and an output mux.
// Assumes: func_in is the signal the cell observes, and func_out drives the
// opposite side (the core for an input pin, the pin for an output pin).
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     tck,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     mode,
    input  logic     ser_in,
    input  logic     func_in,
    output logic     ser_out,
    output logic     func_out
);

    logic shift_q;
    logic upd_q;

    // Shift stage: capture, shift or hold
    always_ff @(posedge tck) begin
        if (!rst_n)
            shift_q <= 1'b0;
        else begin
            case (op)
                OP_CAPTURE: shift_q <= func_in;
                OP_SHIFT:   shift_q <= ser_in;
                default:    shift_q <= shift_q;
            endcase
        end
    end

    // Update latch: loads only on the update strobe
    always_ff @(posedge tck) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else if (upd_en)
            upd_q <= shift_q;
    end

    // Output select: functional path or applied test value
    always_comb begin
        func_out = mode ? upd_q : func_in;
    end

    assign ser_out = shift_q;

    // R4: capture loads the observed signal
    p_capture_load_r4: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_CAPTURE |=> shift_q == $past(func_in));

    // R3: shift takes the neighbour's value
    p_shift_move_r3: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_SHIFT |=> shift_q == $past(ser_in));

    // R9: no strobe leaves the stage unchanged
    p_hold_stage_r9: assert property (@(posedge tck) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(shift_q));

    // R5: the update latch moves only on update
    p_latch_steady_r5: assert property (@(posedge tck) disable iff (!rst_n)
        !upd_en |=> $stable(upd_q));

    // R5: update copies the pre-edge shift value
    p_latch_copy_r5: assert property (@(posedge tck) disable iff (!rst_n)
        upd_en |=> upd_q == $past(shift_q));

endmodule

// File: rtl/bscan_tdo_stage.sv
// Module: retimes the last chain stage onto the falling test-clock edge.
// Assumes: the reset is sampled synchronously on the falling edge.
module bscan_tdo_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic last_bit,
    output logic tdo
);

    logic tdo_q;

    // Falling-edge output register
    always_ff @(negedge tck) begin
        if (!rst_n)
            tdo_q <= 1'b0;
        else
            tdo_q <= last_bit;
    end

    assign tdo = tdo_q;

    // R7: tdo shows the last stage from the previous falling edge
    p_tdo_follow_r7: assert property (@(negedge tck) disable iff (!rst_n)
        $past(rst_n) |-> tdo == $past(last_bit));

endmodule

// File: rtl/bscan_chain.sv
// Module: top of the boundary scan chain. Input-pin cells come first after tdi,
// then output-pin cells, then the falling-edge serial output.
// Assumes: the strobes come from an external test controller, synchronous to tck.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             mode,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pin_out
);

    localparam int LEN = N_IN + N_OUT;

    cell_op_e           op;
    logic [LEN-1:0]     stage_q;
    logic [LEN-1:0]     func_src;
    logic [LEN-1:0]     func_dst;

    bscan_op_decode u_decode (
        .tck     (tck),
        .rst_n   (rst_n),
        .capture (capture),
        .shift   (shift),
        .op      (op)
    );

    // Observed signals, input pins first and then core outputs
    assign func_src = {core_out, pin_in};

    // One cell per stage, stage 0 fed from tdi
    for (genvar k = 0; k < LEN; k++) begin : g_cell
        logic ser_src;
        if (k == 0) begin : g_head
            assign ser_src = tdi;
        end else begin : g_link
            assign ser_src = stage_q[k-1];
        end
        bscan_cell u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .op       (op),
            .upd_en   (update),
            .mode     (mode),
            .ser_in   (ser_src),
            .func_in  (func_src[k]),
            .ser_out  (stage_q[k]),
            .func_out (func_dst[k])
        );
    end

    assign core_in = func_dst[N_IN-1:0];
    assign pin_out = func_dst[LEN-1:N_IN];

    bscan_tdo_stage u_tdo (
        .tck      (tck),
        .rst_n    (rst_n),
        .last_bit (stage_q[LEN-1]),
        .tdo      (tdo)
    );

    // R2: in normal mode the pins and the core connect straight through
    p_bypass_pins_r2: assert property (@(posedge tck) disable iff (!rst_n)
        !mode |-> (core_in == pin_in && pin_out == core_out));

    // R6: in test mode, with no update, the outputs keep their values
    p_test_steady_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (mode && !update) |=> (mode |-> $stable(pin_out)));

endmodule

// File: tb/bscan_chain_bench.sv
// Bench: a behavioural model of the chain, checked against the outputs every cycle.
module bscan_chain_bench;

    localparam int NI  = 5;
    localparam int NO  = 3;
    localparam int LEN = NI + NO;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture = 1'b0, shift = 1'b0, update = 1'b0, mode = 1'b0, tdi = 1'b0;
    logic          tdo;
    logic [NI-1:0] pin_in = '0;
    logic [NI-1:0] core_in;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] pin_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R8";

    // Model state: index 0 nearest tdi
    bit m_sh [LEN];
    bit m_up [LEN];
    bit m_tdo;

    always #10 tck = ~tck;

    bscan_chain #(.N_IN(NI), .N_OUT(NO)) u_bscan_chain (
        .tck(tck), .rst_n(rst_n), .capture(capture), .shift(shift),
        .update(update), .mode(mode), .tdi(tdi), .tdo(tdo),
        .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
    );

    task automatic model_rise();
        bit old [LEN];
        for (int k = 0; k < LEN; k++) old[k] = m_sh[k];
        if (!rst_n) begin
            for (int k = 0; k < LEN; k++) begin m_sh[k] = 0; m_up[k] = 0; end
        end else begin
            if (update)
                for (int k = 0; k < LEN; k++) m_up[k] = old[k];
            if (capture) begin
                for (int i = 0; i < NI; i++) m_sh[i] = pin_in[i];
                for (int j = 0; j < NO; j++) m_sh[NI+j] = core_out[j];
            end else if (shift) begin
                m_sh[0] = tdi;
                for (int k = 1; k < LEN; k++) m_sh[k] = old[k-1];
            end
        end
    endtask

    task automatic check_bit(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [NI-1:0] e_core;
        logic [NO-1:0] e_pin;
        for (int i = 0; i < NI; i++) e_core[i] = mode ? m_up[i] : pin_in[i];
        for (int j = 0; j < NO; j++) e_pin[j] = mode ? m_up[NI+j] : core_out[j];
        check_bit("tdo", tdo, m_tdo);
        n_cmp++;
        if (core_in !== e_core) begin
            n_bad++;
            $display("FAIL %s core_in actual=%b expected=%b t=%0t", tag, core_in, e_core, $time);
        end
        n_cmp++;
        if (pin_out !== e_pin) begin
            n_bad++;
            $display("FAIL %s pin_out actual=%b expected=%b t=%0t", tag, pin_out, e_pin, $time);
        end
    endtask

    // One test-clock cycle: drive, model both edges, compare after the falling edge
    task automatic cyc(bit rn, bit c, bit s, bit u, bit md, bit d,
                       logic [NI-1:0] pi, logic [NO-1:0] co);
        rst_n = rn; capture = c; shift = s; update = u; mode = md; tdi = d;
        pin_in = pi; core_out = co;
        @(posedge tck);
        model_rise();
        @(negedge tck);
        m_tdo = rst_n ? m_sh[LEN-1] : 1'b0;
        #2;
        compare();
    endtask

    initial begin
        logic [LEN-1:0] pat;
        @(negedge tck); #2;
        for (int k = 0; k < LEN; k++) begin m_sh[k] = 0; m_up[k] = 0; end
        m_tdo = 0;
        // R8: reset with activity on the inputs
        tag = "R8";
        for (int n = 0; n < 3; n++)
            cyc(0, 1, 1, 1, 0, 1, NI'($urandom), NO'($urandom));
        // R2: normal mode passes pins through while the chain works
        tag = "R2";
        for (int n = 0; n < 12; n++)
            cyc(1, 1'($urandom), 1'($urandom), 1'($urandom), 0, 1'($urandom),
                NI'($urandom), NO'($urandom));
        // R4: capture a known pattern
        tag = "R4";
        cyc(1, 1, 0, 0, 0, 0, 5'b10110, 3'b011);
        // R1 R7: shift the capture out and observe the order at tdo
        tag = "R1";
        for (int n = 0; n < LEN + 1; n++) cyc(1, 0, 1, 0, 0, 0, '0, '0);
        // R3: shift a pattern into the chain
        tag = "R3";
        pat = 8'b1100_1011;
        for (int n = 0; n < LEN; n++) cyc(1, 0, 1, 0, 0, pat[n], '0, '0);
        // R5: apply the pattern
        tag = "R5";
        cyc(1, 0, 0, 1, 1, 0, 5'b00000, 3'b000);
        // R6: test mode shows the latches while pins and core change
        tag = "R6";
        for (int n = 0; n < 4; n++) cyc(1, 0, 0, 0, 1, 0, NI'($urandom), NO'($urandom));
        // R5: shifting in test mode leaves the outputs still
        tag = "R5";
        for (int n = 0; n < LEN; n++) cyc(1, 0, 1, 0, 1, 1'($urandom), NI'($urandom), NO'($urandom));
        // R4: capture and shift together, capture wins
        tag = "R4";
        cyc(1, 1, 1, 0, 1, 1, 5'b01001, 3'b110);
        // R9: idle cycles hold everything
        tag = "R9";
        for (int n = 0; n < 4; n++) cyc(1, 0, 0, 0, 1, 1, NI'($urandom), NO'($urandom));
        // R7: flush to tdo
        tag = "R7";
        for (int n = 0; n < LEN + 2; n++) cyc(1, 0, 1, 0, 0, 1'($urandom), '0, '0);
        // R3: random mix of all strobes
        tag = "R3";
        for (int n = 0; n < 300; n++)
            cyc(1, ($urandom % 5) == 0, 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
                1'($urandom), NI'($urandom), NO'($urandom));
        // R8: reset in the middle of a run
        tag = "R8";
        cyc(0, 0, 1, 0, 1, 1, NI'($urandom), NO'($urandom));
        for (int n = 0; n < 3; n++) cyc(1, 0, 0, 0, 1, 0, NI'($urandom), NO'($urandom));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog actual=running expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule